// File: doc/BRIEF.md
# Event Word Buffer with Two-Bit Serial Readout

This block collects digitized hits, one per hit channel, and turns each into a fixed 48-bit event word. The word carries two timestamps. The first is a 12-bit bunch-crossing count that runs in its own slow clock domain. The second is an 8-bit count of accepted triggers. Both counters step in Gray code, so a value captured while it changes is never off by more than one count.

Accepted words are held in a 16-entry first-in first-out store and then sent out on a two-wire data path, one 2-bit symbol per data-clock cycle, most significant bits first. A separate sync line marks the first symbol of every word. Words that are waiting go out back to back. When nothing is waiting, both data wires and the sync line stay low. An event that arrives while the store is full is discarded, and the discard is recorded in a counter.

The bunch-crossing value reaches the data-clock domain as Gray code through a two-stage synchronizer. The event inputs and the trigger pulse belong to the data-clock domain.

Top module: `evt_readout`

## Requirements
- R1: While reset is held low at a data-clock edge, dat_o and sync_o are 0 and drop_cnt_o is 0.
- R2: The word has this layout, from bit 47 down to bit 0: bit 47 sparse flag, bit 46 threshold flag, bits 45:40 channel address, bits 39:30 amplitude, bits 29:20 time, bits 19:8 bunch-crossing ID, bits 7:0 trigger ID. Symbol k (k = 0..23) on dat_o carries word bits [47-2k:46-2k].
- R3: Each word takes exactly 24 data-clock cycles. sync_o is 1 during symbol 0 and 0 during symbols 1 to 23.
- R4: The trigger ID field is the Gray code of the number of trig_i pulses counted before the cycle in which the event is written, modulo 256. A trigger in the same cycle as the event is not included in that event.
- R5: The bunch-crossing ID field is the Gray code of the count of clk_bc edges since reset, modulo 4096. It lags the live count by at most 3 counts.
- R6: When the store and the output are both idle, an event written at data-clock edge E appears as symbol 0 (sync_o = 1) after edge E+1, and not after edge E.
- R7: While further words are waiting, symbol 0 of the next word follows symbol 23 of the current word in the very next cycle.
- R8: The store holds 16 words. An event that arrives while it is full is discarded and drop_cnt_o increments by one. The stored words still come out complete and in arrival order.
- R9: With no word in progress and none waiting, dat_o is 00 and sync_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dat | input | 1 | Data/readout clock; event, trigger and output domain |
| clk_bc | input | 1 | Bunch-crossing clock driving the BC counter |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| trig_i | input | 1 | Trigger accept pulse, one count per high cycle |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_sparse_i | input | 1 | Sparse flag of the event |
| evt_thr_i | input | 1 | Threshold flag of the event |
| evt_addr_i | input | 6 | Channel address |
| evt_ampl_i | input | 10 | Amplitude code |
| evt_time_i | input | 10 | Time code |
| dat_o | output | 2 | Serial data symbol |
| sync_o | output | 1 | High during the first symbol of a word |
| drop_cnt_o | output | 16 | Number of events discarded on a full store |

## Verification
A single isolated event with distinct bit patterns in every field shows whether the packing order and symbol order are right, and it also fixes the start latency exactly. Trigger pulses on their own, a trigger in the same cycle as an event, and a run of 300 triggers separate off-by-one counting from failures to wrap. Two events spaced in time check that the bunch-crossing field is a valid Gray value close to the live count and that it advances. A burst of 20 events in consecutive cycles fills the store. It shows which events are dropped, that the drop count is exact, that stored words keep their order, and that words go out with no gaps between them before the lines return to idle.

// File: rtl/evt_pkg.sv
// Shared widths, event word layout and Gray helpers for the event readout block.
package evt_pkg;
    localparam int ADDR_W = 6;
    localparam int AMPL_W = 10;
    localparam int TIME_W = 10;
    localparam int BC_W   = 12;
    localparam int TRG_W  = 8;

    // Field order is the transmission order, most significant first.
    typedef struct packed {
        logic              sparse;
        logic              thr;
        logic [ADDR_W-1:0] addr;
        logic [AMPL_W-1:0] ampl;
        logic [TIME_W-1:0] tstamp;
        logic [BC_W-1:0]   bc_id;
        logic [TRG_W-1:0]  trg_id;
    } evt_word_t;

    localparam int WORD_W = $bits(evt_word_t);
endpackage

// File: rtl/gray_ctr.sv
// Gray-code up counter.
// Holds a binary copy and a registered Gray copy. The Gray output is a flop, so
// another clock domain may sample it. Assumes en is synchronous to clk.
module gray_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] gray_o
);
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nxt;

    // next binary value
    always_comb bin_nxt = bin_q + 1'b1;

    // advance both copies on enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else if (en) begin
            bin_q  <= bin_nxt;
            gray_o <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    // R4/R5: exactly one bit flips per counted step
    a_r4_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($countones(gray_o ^ $past(gray_o)) == 1));
    // R4: no count without enable
    a_r4_gray_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(gray_o));
endmodule

// File: rtl/gray_sync.sv
// Two-stage synchronizer for a Gray-coded bus.
// Assumes the source changes at most one bit between destination samples.
module gray_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;

    // two flops in the destination domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q_o      <= '0;
        end else begin
            stage1_q <= d_i;
            q_o      <= stage1_q;
        end
    end

    // R5: a synchronized Gray value moves by at most one bit per cycle
    a_r5_sync_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_o ^ $past(q_o)) <= 1);
endmodule

// File: rtl/evt_fifo.sv
// Single-clock first-in first-out store with show-ahead read data.
// A write while full is refused; the caller accounts for it.
module evt_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;
    logic          do_wr, do_rd;

    // qualified strobes
    always_comb begin
        do_wr = wr_en && !full_o;
        do_rd = rd_en && !empty_o;
    end

    // status flags from occupancy
    always_comb begin
        empty_o = (count_q == '0);
        full_o  = (count_q == CW'(DEPTH));
        rd_data = mem[rptr_q];
    end

    // storage array, no reset needed
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr_q] <= wr_data;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_wr) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (do_rd) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R8: occupancy never exceeds the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R8: a refused write leaves occupancy unchanged unless a read happens
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !rd_en) |=> full_o);
endmodule

// File: rtl/word_ser.sv
// Word-to-symbol serializer.
// Loads a word when one is available and it is idle or finishing a word, then
// shifts SYM_W bits per cycle, most significant first. Sync marks symbol 0.
module word_ser #(
    parameter int W     = 48,
    parameter int SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     word_i,
    input  logic             avail_i,
    output logic             pop_o,
    output logic [SYM_W-1:0] dat_o,
    output logic             sync_o,
    output logic             busy_o
);
    localparam int NSYM = W / SYM_W;
    localparam int CW   = $clog2(NSYM);

    logic [W-1:0]  shreg_q;
    logic [CW-1:0] idx_q;
    logic          last_sym;

    // end-of-word and load decision
    always_comb begin
        last_sym = busy_o && (idx_q == CW'(NSYM - 1));
        pop_o    = avail_i && (!busy_o || last_sym);
    end

    // shift register, symbol index and activity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
            busy_o  <= 1'b0;
        end else if (pop_o) begin
            shreg_q <= word_i;
            idx_q   <= '0;
            busy_o  <= 1'b1;
        end else if (last_sym) begin
            busy_o  <= 1'b0;
            idx_q   <= '0;
        end else if (busy_o) begin
            shreg_q <= shreg_q << SYM_W;
            idx_q   <= idx_q + 1'b1;
        end
    end

    // line drivers: idle low
    always_comb begin
        dat_o  = busy_o ? shreg_q[W-1 -: SYM_W] : '0;
        sync_o = busy_o && (idx_q == '0);
    end

    // R3: a sync symbol is never followed by another sync symbol
    a_r3_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);
    // R3: symbol index stays inside one word
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= CW'(NSYM - 1));
endmodule

// File: rtl/evt_readout.sv
// Event word builder, buffer and two-wire serial readout.
// Timestamps each event with a Gray bunch-crossing ID (from clk_bc, synchronized)
// and a Gray trigger ID, queues the word, and streams it with a sync marker.
// Assumes event and trigger inputs are synchronous to clk_dat and that clk_dat
// is at least twice as fast as clk_bc.
module evt_readout
    import evt_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int SYM_W      = 2,
    parameter int DROP_W     = 16
) (
    input  logic              clk_dat,
    input  logic              clk_bc,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              evt_valid_i,
    input  logic              evt_sparse_i,
    input  logic              evt_thr_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic [AMPL_W-1:0] evt_ampl_i,
    input  logic [TIME_W-1:0] evt_time_i,
    output logic [SYM_W-1:0]  dat_o,
    output logic              sync_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    logic [BC_W-1:0]  bc_gray_src, bc_gray_dat;
    logic [TRG_W-1:0] trg_gray;
    evt_word_t        new_word;
    logic [WORD_W-1:0] head_word;
    logic             fifo_empty, fifo_full, ser_pop, ser_busy, drop_ev;

    // bunch-crossing counter in its own domain
    gray_ctr #(.W(BC_W)) u_bc_ctr (
        .clk(clk_bc), .rst_n(rst_n), .en(1'b1), .gray_o(bc_gray_src));

    // bring BC into the data domain
    gray_sync #(.W(BC_W)) u_bc_sync (
        .clk(clk_dat), .rst_n(rst_n), .d_i(bc_gray_src), .q_o(bc_gray_dat));

    // trigger counter in the data domain
    gray_ctr #(.W(TRG_W)) u_trg_ctr (
        .clk(clk_dat), .rst_n(rst_n), .en(trig_i), .gray_o(trg_gray));

    // assemble the event word with the counters as seen this cycle
    always_comb begin
        new_word.sparse = evt_sparse_i;
        new_word.thr    = evt_thr_i;
        new_word.addr   = evt_addr_i;
        new_word.ampl   = evt_ampl_i;
        new_word.tstamp = evt_time_i;
        new_word.bc_id  = bc_gray_dat;
        new_word.trg_id = trg_gray;
        drop_ev         = evt_valid_i && fifo_full;
    end

    // word buffer
    evt_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk_dat), .rst_n(rst_n),
        .wr_en(evt_valid_i), .wr_data(new_word),
        .rd_en(ser_pop), .rd_data(head_word),
        .empty_o(fifo_empty), .full_o(fifo_full));

    // serial output stage
    word_ser #(.W(WORD_W), .SYM_W(SYM_W)) u_ser (
        .clk(clk_dat), .rst_n(rst_n),
        .word_i(head_word), .avail_i(!fifo_empty), .pop_o(ser_pop),
        .dat_o(dat_o), .sync_o(sync_o), .busy_o(ser_busy));

    // saturating count of discarded events
    always_ff @(posedge clk_dat) begin
        if (!rst_n)                            drop_cnt_o <= '0;
        else if (drop_ev && (drop_cnt_o != '1)) drop_cnt_o <= drop_cnt_o + 1'b1;
    end

    // R8: the drop count never goes down
    a_r8_drop_mono: assert property (@(posedge clk_dat) disable iff (!rst_n)
        drop_cnt_o >= $past(drop_cnt_o));
    // R6: a waiting word starts on the next edge when the output is idle
    a_r6_start: assert property (@(posedge clk_dat) disable iff (!rst_n)
        (!ser_busy && !fifo_empty) |=> sync_o);
    // R9: nothing waiting and nothing in flight keeps the lines low
    a_r9_idle_low: assert property (@(posedge clk_dat) disable iff (!rst_n)
        (!ser_busy && fifo_empty) |-> (dat_o == '0 && !sync_o));
    // R1: outputs cleared by reset
    a_r1_reset: assert property (@(posedge clk_dat)
        !rst_n |=> (!sync_o && drop_cnt_o == '0));
endmodule

// File: tb/evt_readout_tb.sv
// Directed bench for evt_readout: one task per scenario, each checking itself.
module evt_readout_tb;
    logic clk_dat = 1'b0, clk_bc = 1'b0, rst_n = 1'b0;
    logic trig_i = 1'b0, evt_valid_i = 1'b0, evt_sparse_i = 1'b0, evt_thr_i = 1'b0;
    logic [5:0]  evt_addr_i = '0;
    logic [9:0]  evt_ampl_i = '0, evt_time_i = '0;
    logic [1:0]  dat_o;
    logic        sync_o;
    logic [15:0] drop_cnt_o;

    int n_chk = 0, n_err = 0;
    int trig_cnt = 0;
    int bc_cnt = 0;
    bit done = 1'b0;

    evt_readout u_dut (
        .clk_dat(clk_dat), .clk_bc(clk_bc), .rst_n(rst_n), .trig_i(trig_i),
        .evt_valid_i(evt_valid_i), .evt_sparse_i(evt_sparse_i), .evt_thr_i(evt_thr_i),
        .evt_addr_i(evt_addr_i), .evt_ampl_i(evt_ampl_i), .evt_time_i(evt_time_i),
        .dat_o(dat_o), .sync_o(sync_o), .drop_cnt_o(drop_cnt_o));

    always #10 clk_dat = ~clk_dat;                 // 50 MHz
    initial begin #5; forever #20 clk_bc = ~clk_bc; end  // half rate, edges offset

    // reference count of bunch-crossing edges since reset
    always @(posedge clk_bc) bc_cnt <= rst_n ? bc_cnt + 1 : 0;

    function automatic logic [11:0] g2b12(input logic [11:0] g);
        logic [11:0] b;
        b[11] = g[11];
        for (int i = 10; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [7:0] b2g8(input int v);
        logic [7:0] b;
        b = 8'(v);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one event for one cycle; returns at the negedge after the write edge
    task automatic send_evt(input bit sp, input bit th, input logic [5:0] a,
                            input logic [9:0] am, input logic [9:0] tm,
                            input bit with_trig, output int bc_ref);
        evt_valid_i = 1'b1; evt_sparse_i = sp; evt_thr_i = th;
        evt_addr_i = a; evt_ampl_i = am; evt_time_i = tm; trig_i = with_trig;
        bc_ref = bc_cnt;
        @(negedge clk_dat);
        evt_valid_i = 1'b0; trig_i = 1'b0;
        if (with_trig) trig_cnt++;
    endtask

    task automatic pulse_trig(input int n);
        for (int i = 0; i < n; i++) begin
            trig_i = 1'b1; @(negedge clk_dat); trig_i = 1'b0; trig_cnt++;
        end
    endtask

    task automatic wait_sync();
        int t = 0;
        while (!sync_o && t < 200) begin @(negedge clk_dat); t++; end
        chk(sync_o, "R6 word start", 64'(sync_o), 64'd1);
    endtask

    // read 24 symbols starting at a negedge where sync_o is high
    task automatic recv_word(output logic [47:0] w);
        w = '0;
        for (int k = 0; k < 24; k++) begin
            if (k > 0) chk(!sync_o, "R3 sync only on symbol 0", 64'(sync_o), 64'd0);
            w = {w[45:0], dat_o};
            @(negedge clk_dat);
        end
    endtask

    task automatic chk_bc(input logic [47:0] w, input int bc_ref, input string tag);
        logic [11:0] dec, diff;
        dec  = g2b12(w[19:8]);
        diff = 12'(bc_ref) - dec;
        chk(diff <= 12'd3, tag, 64'(dec), 64'(bc_ref));
    endtask

    task automatic chk_idle(input int n);
        for (int i = 0; i < n; i++) begin
            chk(dat_o == 2'b00 && !sync_o, "R9 idle lines low",
                64'({dat_o, sync_o}), 64'd0);
            @(negedge clk_dat);
        end
    endtask

    task automatic t_reset();
        @(negedge clk_dat);
        chk(dat_o == 2'b00, "R1 dat_o in reset", 64'(dat_o), 64'd0);
        chk(!sync_o, "R1 sync_o in reset", 64'(sync_o), 64'd0);
        chk(drop_cnt_o == 16'd0, "R1 drop count in reset", 64'(drop_cnt_o), 64'd0);
        repeat (9) @(negedge clk_dat);
        rst_n = 1'b1;
        @(negedge clk_dat);
    endtask

    // single isolated event: packing, symbol order, latency, idle afterwards
    task automatic t_single();
        logic [47:0] w, exp;
        int bref;
        send_evt(1'b1, 1'b0, 6'h2A, 10'h3C5, 10'h0F1, 1'b0, bref);
        chk(!sync_o, "R6 no start after write edge", 64'(sync_o), 64'd0);
        @(negedge clk_dat);
        chk(sync_o, "R6 start one edge later", 64'(sync_o), 64'd1);
        recv_word(w);
        exp = {1'b1, 1'b0, 6'h2A, 10'h3C5, 10'h0F1, 12'h000, b2g8(trig_cnt)};
        chk({w[47:20], w[7:0]} == {exp[47:20], exp[7:0]}, "R2 field layout",
            64'(w), 64'(exp));
        chk(w[7:0] == 8'h00, "R4 no triggers yet", 64'(w[7:0]), 64'd0);
        chk_bc(w, bref, "R5 BC near live count");
        chk_idle(4);
    endtask

    // trigger counting, same-cycle exclusion and wrap
    task automatic t_trig();
        logic [47:0] w;
        int bref;
        logic [7:0] exp;
        pulse_trig(5);
        exp = b2g8(trig_cnt);
        send_evt(1'b0, 1'b1, 6'h15, 10'h155, 10'h2AA, 1'b1, bref);
        wait_sync(); recv_word(w);
        chk(w[7:0] == exp, "R4 same-cycle trigger excluded", 64'(w[7:0]), 64'(exp));
        chk(w[47:20] == {1'b0, 1'b1, 6'h15, 10'h155, 10'h2AA}, "R2 payload bits",
            64'(w[47:20]), 64'({1'b0, 1'b1, 6'h15, 10'h155, 10'h2AA}));
        pulse_trig(300 - trig_cnt);
        exp = b2g8(trig_cnt);
        send_evt(1'b0, 1'b0, 6'h01, 10'h001, 10'h200, 1'b0, bref);
        wait_sync(); recv_word(w);
        chk(w[7:0] == exp, "R4 wrap modulo 256", 64'(w[7:0]), 64'(exp));
        chk_idle(2);
    endtask

    // bunch-crossing field over time
    task automatic t_bc();
        logic [47:0] w1, w2;
        int b1, b2;
        logic [11:0] step;
        send_evt(1'b0, 1'b0, 6'h3F, 10'h000, 10'h3FF, 1'b0, b1);
        wait_sync(); recv_word(w1);
        repeat (16) @(negedge clk_dat);
        send_evt(1'b1, 1'b1, 6'h00, 10'h3FF, 10'h000, 1'b0, b2);
        wait_sync(); recv_word(w2);
        chk_bc(w1, b1, "R5 first BC in window");
        chk_bc(w2, b2, "R5 second BC in window");
        step = g2b12(w2[19:8]) - g2b12(w1[19:8]);
        chk(step >= 12'(b2 - b1 - 3) && step <= 12'(b2 - b1 + 3), "R5 BC advance",
            64'(step), 64'(b2 - b1));
        chk_idle(2);
    endtask

    // 20 back-to-back events: fill, drop, order, gap-free output
    task automatic t_burst();
        int base;
        base = trig_cnt;
        fork
            begin
                for (int i = 0; i < 20; i++) begin
                    evt_valid_i = 1'b1; evt_sparse_i = i[0]; evt_thr_i = i[1];
                    evt_addr_i = 6'(i); evt_ampl_i = 10'(i * 37); evt_time_i = 10'(1000 - i);
                    @(negedge clk_dat);
                end
                evt_valid_i = 1'b0;
                chk(drop_cnt_o == 16'd3, "R8 three events dropped", 64'(drop_cnt_o), 64'd3);
            end
            begin
                logic [47:0] w;
                wait_sync();
                for (int i = 0; i < 17; i++) begin
                    recv_word(w);
                    chk(w[47:20] == {i[0], i[1], 6'(i), 10'(i * 37), 10'(1000 - i)},
                        "R8 stored order", 64'(w[47:20]),
                        64'({i[0], i[1], 6'(i), 10'(i * 37), 10'(1000 - i)}));
                    chk(w[7:0] == b2g8(base), "R4 trigger ID in burst",
                        64'(w[7:0]), 64'(b2g8(base)));
                    if (i < 16)
                        chk(sync_o, "R7 next word without gap", 64'(sync_o), 64'd1);
                end
            end
        join
        chk_idle(3);
        chk(drop_cnt_o == 16'd3, "R8 drop count stable", 64'(drop_cnt_o), 64'd3);
    endtask

    initial begin
        t_reset();
        t_single();
        t_trig();
        t_bc();
        t_burst();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk_dat);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule